// File: doc/BRIEF.md
# Strobed Input Port with Handshake

This block is an 8-bit latched input port for a parallel peripheral that uses a two-wire handshake. The peripheral puts a byte on the port pins and pulses an active-low strobe. The port takes the byte into a holding register and raises a buffer-full flag, which tells the peripheral to hold off. When the strobe returns high, the port raises an interrupt request to the CPU, provided the flag is still set and interrupts are enabled.

The CPU uses a synchronous read interface. A read cycle is a level on `cpu_rd` that lasts one or more clocks, and `cpu_sel` picks between the data register and a status word. When a data read begins, the interrupt request drops. When that read ends, the buffer-full flag drops and the peripheral may send the next byte. If a byte arrives while the buffer is still full, it overwrites the holding register and an overrun status bit is set. The strobe and the pin data pass through two flip-flops before use, so the strobe may be fully asynchronous to `clk`.

Top module: `strobed_in_port`

## Requirements
- R1: While `rst_n` is low, and after its release, the holding register, the buffer-full flag, the interrupt request, the overrun bit and the interrupt-enable bit are all 0.
- R2: A falling edge of `stb_n` sets `ibf` on the third rising clock edge after the pin change. The holding register then contains the byte that was on `pin_data` when the strobe fell.
- R3: A rising edge of `stb_n` sets `irq` on the third rising clock edge after the pin change, if `ibf` and the enable bit are both 1 at that time.
- R4: While the enable bit is 0, a strobe sets `ibf` but never sets `irq`.
- R5: While `cpu_sel` is 0, `rd_data` shows the holding register. The first clock of a data read (`cpu_rd` high, `cpu_sel` 0) clears `irq` at that edge and leaves `ibf` set.
- R6: The first clock edge after a data read ends (`cpu_rd` low) clears `ibf` and the overrun bit.
- R7: A strobe falling edge that is detected while `ibf` is 1 replaces the holding register with the new byte and sets the overrun bit.
- R8: While `cpu_sel` is 1, `rd_data` shows the status word: bit 0 = buffer full, bit 1 = interrupt request, bit 2 = overrun, bit 3 = interrupt enable, and the upper bits are 0. A status read does not clear any of these bits.
- R9: When `cpu_wr` is high at a clock edge, the enable bit takes the value of `cpu_wdata`.
- R10: A strobe must stay low for at least two clock periods so that the two-stage synchronizer sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_data | input | 8 | Byte from the peripheral |
| stb_n | input | 1 | Active-low strobe from the peripheral, asynchronous |
| cpu_rd | input | 1 | CPU read cycle, high for the length of the cycle |
| cpu_sel | input | 1 | 0 selects the data register, 1 selects the status word |
| cpu_wr | input | 1 | Write strobe for the enable bit |
| cpu_wdata | input | 1 | New value of the interrupt-enable bit |
| rd_data | output | 8 | Selected data register or status word |
| ibf | output | 1 | Buffer full, returned to the peripheral |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
Strobe edges take three clocks to reach the outputs: two synchronizer stages and one edge-detect register. The bench therefore drives the strobe on a falling clock edge and samples `ibf`, `irq` and the data on the third falling edge after that. A read start clears `irq` at the next rising edge, and a read end clears `ibf` at the next rising edge, so both are checked half a clock later. `rd_data` is combinational and is sampled one time unit after `cpu_sel` is driven. The bench sends all 256 byte values with the enable bit alternating, and checks the overrun, status-read and disabled-interrupt cases separately.

// File: rtl/strobed_in_port.sv
module strobed_in_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pin_data,
  input  logic          stb_n,
  input  logic          cpu_rd,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic          cpu_wdata,
  output logic [DW-1:0] rd_data,
  output logic          ibf,
  output logic          irq
);

  localparam int STW = 4;

  logic [2:0]    stb_sh;
  logic [DW-1:0] pin_q1, pin_q2, hold;
  logic          ovr, ie, rd_q, rd_data_q;
  logic          stb_fall, stb_rise, rd_go, rd_done;
  logic [DW-1:0] status;

  // R10: two synchronizer stages plus one history stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_sh <= '1;
      pin_q1 <= '0;
      pin_q2 <= '0;
    end else begin
      stb_sh <= {stb_sh[1:0], stb_n};
      pin_q1 <= pin_data;
      pin_q2 <= pin_q1;
    end
  end

  assign stb_fall = stb_sh[2] & ~stb_sh[1];
  assign stb_rise = ~stb_sh[2] & stb_sh[1];
  assign rd_go    = cpu_rd & ~rd_q & ~cpu_sel;
  assign rd_done  = ~cpu_rd & rd_q & rd_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      rd_data_q <= 1'b0;
    end else begin
      rd_q <= cpu_rd;
      if (cpu_rd && !rd_q) rd_data_q <= ~cpu_sel;
      else if (!cpu_rd)    rd_data_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      ibf  <= 1'b0;
      ovr  <= 1'b0;
    end else if (stb_fall) begin
      hold <= pin_q2;
      ibf  <= 1'b1;
      if (ibf && !rd_done) ovr <= 1'b1;
    end else if (rd_done) begin
      ibf <= 1'b0;
      ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  irq <= 1'b0;
    else if (rd_go)              irq <= 1'b0;
    else if (stb_rise && ibf && ie) irq <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ie <= 1'b0;
    else if (cpu_wr) ie <= cpu_wdata;
  end

  assign status  = {{(DW-STW){1'b0}}, ie, ovr, irq, ibf};
  assign rd_data = cpu_sel ? status : hold;

  assert_fall_sets_ibf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> ibf);
  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(stb_rise) && $past(ie));
  assert_no_irq_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |=> !$rose(irq));
  assert_read_clears_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !irq);
  assert_read_end_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !stb_fall) |=> !ibf && !ovr);
  assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && ibf && !rd_done) |=> ovr);
  assert_ibf_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && !rd_done) |=> ibf);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !ibf && !irq && !ovr && !ie);

endmodule

// File: tb/sim_strobed_in_port.sv
`timescale 1ns/1ps
module sim_strobed_in_port;
  logic       clk = 0, rst_n = 0;
  logic [7:0] pin_data = 8'h00;
  logic       stb_n = 1, cpu_rd = 0, cpu_sel = 0, cpu_wr = 0, cpu_wdata = 0;
  logic [7:0] rd_data;
  logic       ibf, irq;
  int         checks = 0, fails = 0;
  logic       done = 0;

  always #10 clk = ~clk;

  strobed_in_port u0 (.clk, .rst_n, .pin_data, .stb_n, .cpu_rd, .cpu_sel,
                      .cpu_wr, .cpu_wdata, .rd_data, .ibf, .irq);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ie(input logic v);
    @(negedge clk); cpu_wr = 1; cpu_wdata = v;
    @(negedge clk); cpu_wr = 0;
    cpu_sel = 1; #1;
    chk(rd_data[3], v, "R9 enable write");
    cpu_sel = 0;
  endtask

  task automatic strobe(input logic [7:0] v, input logic ie_now, input logic was_ibf);
    @(negedge clk); pin_data = v; stb_n = 0;
    repeat (2) @(negedge clk);
    chk(ibf, was_ibf, "R2 ibf not yet set");
    @(negedge clk);
    chk(ibf, 1'b1, "R2 ibf set");
    cpu_sel = 0; #1;
    chk(rd_data, v, "R2 captured byte");
    @(negedge clk); stb_n = 1; pin_data = ~v;
    repeat (3) @(negedge clk);
    chk(irq, ie_now, ie_now ? "R3 irq on rise" : "R4 irq disabled");
  endtask

  task automatic data_read(input logic [7:0] v);
    @(negedge clk); cpu_sel = 0; cpu_rd = 1; #1;
    chk(rd_data, v, "R5 read data");
    @(negedge clk);
    chk(irq, 1'b0, "R5 irq cleared at read start");
    chk(ibf, 1'b1, "R5 ibf kept during read");
    cpu_rd = 0;
    @(negedge clk);
    chk(ibf, 1'b0, "R6 ibf cleared at read end");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    pin_data = 8'hA5;
    cpu_sel = 1; #1;
    chk(rd_data, 8'h00, "R1 status in reset");
    chk({ibf, irq}, 2'b00, "R1 flags in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk); cpu_sel = 0; #1;
    chk(rd_data, 8'h00, "R1 holding register after reset");

    for (int i = 0; i < 256; i++) begin
      logic e;
      e = i[0];
      set_ie(e);
      strobe(i[7:0], e, 1'b0);
      data_read(i[7:0]);
    end

    set_ie(1'b0);
    strobe(8'h3C, 1'b0, 1'b0);
    cpu_sel = 1; #1;
    chk(rd_data, 8'h01, "R4 status ibf only, no irq");
    cpu_sel = 0;
    data_read(8'h3C);

    set_ie(1'b1);
    strobe(8'h11, 1'b1, 1'b0);
    strobe(8'h22, 1'b1, 1'b1);
    cpu_sel = 1; #1;
    chk(rd_data, 8'h0F, "R7 overrun status");
    @(negedge clk); cpu_rd = 1;
    @(negedge clk); cpu_rd = 0;
    @(negedge clk); #1;
    chk(rd_data, 8'h0F, "R8 status read no side effect");
    cpu_sel = 0; #1;
    chk(rd_data, 8'h22, "R7 overwritten byte");
    data_read(8'h22);
    cpu_sel = 1; #1;
    chk(rd_data, 8'h08, "R6 overrun cleared by read");
    cpu_sel = 0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule